// File: doc/BRIEF.md
# Ramp-Completion Interrupt Flag Unit

This block gathers seven event sources into a sticky flag register, filters them through a mask register and drives one level-sensitive interrupt line. Three of the sources are pulses from outside: short-circuit release, jack detect and short-circuit. The other four come from two ramp sequencers inside the block. The gain sequencer moves a 5-bit playback gain code one step per tick whenever the playback mute control changes. The output-stage sequencer moves a 5-bit output level whenever the headphone stage is switched on or off. Each sequencer raises a completion flag in the cycle it reaches its end value.

Software talks to the block through a simple write port. That port carries the playback control, the headphone control, the flag clear (write a one to a bit to clear it), the mask and the tick period. Flags and mask are visible as outputs, and so are the two ramp levels. Driver code starts a mute or power change, waits for the interrupt and then clears the flag.

Top module: `ramp_irq_unit`

## Requirements
- R1: After reset, every flag is 0, the mask is 0x7F (all sources masked), both ramp levels are 0, the tick period is 1 and irq_o is 0. The playback control starts muted and in standby, and the headphone stage starts off.
- R2: The flag bits are: bit 6 short-circuit release (event_i[2]), bit 5 jack (event_i[1]), bit 4 short-circuit (event_i[0]), bit 3 output ramp-up done, bit 2 output ramp-down done, bit 1 gain ramp-up done and bit 0 gain ramp-down done. An event sets its bit at the next clock edge, and the bit stays set until it is cleared.
- R3: A write to address 2 clears every flag bit whose data bit is 1 and leaves the bits written as 0 unchanged. Writing 0x7F clears all flags.
- R4: A write to address 3 loads the mask. A mask bit of 1 masks its source. irq_o is the OR of all flag bits whose mask bit is 0.
- R5: If a source sets a flag in the same cycle as a write-one clear of that bit, the flag ends up set.
- R6: Address 0 is the playback control: bit 7 is mute and bit 4 is standby. A write that changes mute while bit 4 is 0 ramps the gain level down to 0 (mute) or up to 31 (unmute), one code per step. The matching flag (bit 0 or bit 1) is set at the same edge at which the level reaches its end value.
- R7: Address 4 holds the tick period P. A ramp steps every P+1 cycles, and the first step falls P+1 edges after the edge that captured the write.
- R8: Any write to address 0 with bit 4 set puts the gain level directly at the end value of the written mute bit and cancels any running gain ramp. No gain flag is raised.
- R9: Reversing mute during a gain ramp restarts the ramp from the current level in the new direction. Only the flag for the final direction is raised.
- R10: Address 1 is the headphone control: bit 7 is mute and bit 3 is common-mode standby. The stage is on when both bits are 0. A change of the on state ramps the output level up to 31 (flag bit 3) or down to 0 (flag bit 2) with the same tick. A write that leaves the on state unchanged has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 8 | Write data |
| event_i | input | 3 | External event pulses: [2] short-circuit release, [1] jack, [0] short-circuit |
| irq_o | output | 1 | Interrupt, OR of the unmasked flags |
| flag_o | output | 7 | Flag register |
| mask_o | output | 7 | Mask register |
| gain_level_o | output | 5 | Current playback gain ramp level |
| out_level_o | output | 5 | Current output-stage ramp level |

## Verification
Some rules are checked by the assertions on every cycle. A set flag stays set, a write-one clear takes effect and a set beats a clear. A fully masked unit keeps its interrupt low. A ramp level moves by at most one code, and only on a tick boundary. A completion pulse leaves the level at its end value. A standby write never produces a gain flag. Other behaviours need the directed scenarios to show them. These are the exact cycle at which a flag appears for a given tick period, the single flag left after a mid-ramp reversal, the bit-to-source mapping, and the headphone writes that must leave the output untouched.

// File: rtl/ramp_irq_pkg.sv
package ramp_irq_pkg;

  localparam int NFLAG = 7;

  // Flag bit positions (shared by flag and mask registers)
  localparam int F_GAIN_DN = 0;
  localparam int F_GAIN_UP = 1;
  localparam int F_OUT_DN  = 2;
  localparam int F_OUT_UP  = 3;
  localparam int F_SHORT   = 4;
  localparam int F_JACK    = 5;
  localparam int F_SCREL   = 6;

  // Register addresses
  localparam int A_PLAY = 0;
  localparam int A_HPH  = 1;
  localparam int A_FLAG = 2;
  localparam int A_MASK = 3;
  localparam int A_TICK = 4;

  // Control bit positions
  localparam int PLAY_MUTE_BIT  = 7;
  localparam int PLAY_STBY_BIT  = 4;
  localparam int HPH_MUTE_BIT   = 7;
  localparam int HPH_CMSB_BIT   = 3;

  // Ramp channel indices
  localparam int CH_GAIN = 0;
  localparam int CH_OUT  = 1;
  localparam int NCH     = 2;

  typedef struct packed {
    logic start;
    logic up;
    logic snap;
  } ramp_cmd_t;

endpackage

// File: rtl/ramp_ctrl_regs.sv
module ramp_ctrl_regs
  import ramp_irq_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 8,
  parameter int TICK_W   = 8,
  parameter int TICK_RST = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [TICK_W-1:0] tick_period,
  output ramp_cmd_t         gain_cmd,
  output ramp_cmd_t         out_cmd,
  output logic [NFLAG-1:0]  flag_clr,
  output logic              mask_we,
  output logic [NFLAG-1:0]  mask_wdata
);

  function automatic logic stage_on(input logic [DATA_W-1:0] v);
    return !v[HPH_MUTE_BIT] && !v[HPH_CMSB_BIT];
  endfunction

  logic              play_mute_q;
  logic              hph_on_q;
  logic [TICK_W-1:0] tick_q;

  logic play_hit, hph_hit, flag_hit, mask_hit, tick_hit;

  assign play_hit = we && (addr == ADDR_W'(A_PLAY));
  assign hph_hit  = we && (addr == ADDR_W'(A_HPH));
  assign flag_hit = we && (addr == ADDR_W'(A_FLAG));
  assign mask_hit = we && (addr == ADDR_W'(A_MASK));
  assign tick_hit = we && (addr == ADDR_W'(A_TICK));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      play_mute_q <= 1'b1;
      hph_on_q    <= 1'b0;
      tick_q      <= TICK_W'(TICK_RST);
    end else begin
      if (play_hit) play_mute_q <= wdata[PLAY_MUTE_BIT];
      if (hph_hit)  hph_on_q    <= stage_on(wdata);
      if (tick_hit) tick_q      <= wdata[TICK_W-1:0];
    end
  end

  assign tick_period = tick_q;

  always_comb begin
    gain_cmd.snap  = play_hit && wdata[PLAY_STBY_BIT];
    gain_cmd.start = play_hit && !wdata[PLAY_STBY_BIT] &&
                     (wdata[PLAY_MUTE_BIT] != play_mute_q);
    gain_cmd.up    = !wdata[PLAY_MUTE_BIT];

    out_cmd.snap   = 1'b0;
    out_cmd.start  = hph_hit && (stage_on(wdata) != hph_on_q);
    out_cmd.up     = stage_on(wdata);
  end

  assign flag_clr   = flag_hit ? wdata[NFLAG-1:0] : '0;
  assign mask_we    = mask_hit;
  assign mask_wdata = wdata[NFLAG-1:0];

endmodule

// File: rtl/level_ramp.sv
module level_ramp
  import ramp_irq_pkg::*;
#(
  parameter int LVL_W  = 5,
  parameter int TICK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TICK_W-1:0] period,
  input  ramp_cmd_t         cmd,
  output logic [LVL_W-1:0]  level,
  output logic              done_up,
  output logic              done_dn
);

  localparam logic [LVL_W-1:0] LVL_MAX = {LVL_W{1'b1}};

  function automatic logic [LVL_W-1:0] endpoint(input logic up);
    return up ? LVL_MAX : '0;
  endfunction

  function automatic logic [LVL_W-1:0] stepped(input logic [LVL_W-1:0] l,
                                               input logic up);
    return up ? l + 1'b1 : l - 1'b1;
  endfunction

  logic [LVL_W-1:0]  level_q;
  logic [TICK_W-1:0] cnt_q;
  logic              active_q;
  logic              dir_q;

  logic             tick_now;
  logic [LVL_W-1:0] nxt;
  logic             start_hit;
  logic             step_hit;

  assign tick_now  = active_q && (cnt_q == period);
  assign nxt       = stepped(level_q, dir_q);
  assign start_hit = cmd.start && !cmd.snap && (level_q == endpoint(cmd.up));
  assign step_hit  = tick_now && !cmd.start && !cmd.snap &&
                     (nxt == endpoint(dir_q));

  assign done_up = (start_hit && cmd.up)  || (step_hit && dir_q);
  assign done_dn = (start_hit && !cmd.up) || (step_hit && !dir_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_q  <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
      dir_q    <= 1'b0;
    end else if (cmd.snap) begin
      level_q  <= endpoint(cmd.up);
      cnt_q    <= '0;
      active_q <= 1'b0;
      dir_q    <= cmd.up;
    end else if (cmd.start) begin
      cnt_q    <= '0;
      dir_q    <= cmd.up;
      active_q <= (level_q != endpoint(cmd.up));
    end else if (active_q) begin
      if (tick_now) begin
        level_q <= nxt;
        cnt_q   <= '0;
        if (nxt == endpoint(dir_q)) active_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign level = level_q;

  // R6: level moves one code at a time unless snapped
  assert_single_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd.snap |=> ({1'b0, level_q} == {1'b0, $past(level_q)}) ||
                  ({1'b0, level_q} == {1'b0, $past(level_q)} + 1'b1) ||
                  ({1'b0, level_q} + 1'b1 == {1'b0, $past(level_q)}));

  assert_done_up_at_max_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_up |=> (level_q == LVL_MAX));

  assert_done_dn_at_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_dn |=> (level_q == '0));

  // R7: a non-snap level change happens only on a tick boundary
  assert_tick_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((level_q != $past(level_q)) && !$past(cmd.snap)) |-> $past(cnt_q == period));

  // R9: at most one direction completes per cycle
  assert_one_direction_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_up, done_dn}));

endmodule

// File: rtl/flag_bank.sv
module flag_bank
  import ramp_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] set_vec,
  input  logic [NFLAG-1:0] clr_vec,
  input  logic             mask_we,
  input  logic [NFLAG-1:0] mask_wdata,
  output logic [NFLAG-1:0] flag_q,
  output logic [NFLAG-1:0] mask_q,
  output logic             irq
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= '0;
      mask_q <= '1;
    end else begin
      flag_q <= (flag_q & ~clr_vec) | set_vec;
      if (mask_we) mask_q <= mask_wdata;
    end
  end

  assign irq = |(flag_q & ~mask_q);

  // R5: a set always lands, even against a clear
  assert_set_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((flag_q & $past(set_vec)) == $past(set_vec)));

  assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec != '0) && (set_vec == '0)) |=> ((flag_q & $past(clr_vec)) == '0));

  assert_flags_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec == '0) && (set_vec == '0)) |=> (flag_q == $past(flag_q)));

  assert_masked_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |-> !irq);

endmodule

// File: rtl/ramp_irq_unit.sv
module ramp_irq_unit
  import ramp_irq_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 8,
  parameter int LVL_W    = 5,
  parameter int TICK_W   = 8,
  parameter int TICK_RST = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic [2:0]        event_i,
  output logic              irq_o,
  output logic [NFLAG-1:0]  flag_o,
  output logic [NFLAG-1:0]  mask_o,
  output logic [LVL_W-1:0]  gain_level_o,
  output logic [LVL_W-1:0]  out_level_o
);

  logic [TICK_W-1:0] tick_period;
  ramp_cmd_t         gain_cmd;
  ramp_cmd_t         out_cmd;
  logic [NFLAG-1:0]  flag_clr;
  logic              mask_we;
  logic [NFLAG-1:0]  mask_wdata;

  ramp_ctrl_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TICK_W(TICK_W), .TICK_RST(TICK_RST)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (cfg_we),
    .addr       (cfg_addr),
    .wdata      (cfg_wdata),
    .tick_period(tick_period),
    .gain_cmd   (gain_cmd),
    .out_cmd    (out_cmd),
    .flag_clr   (flag_clr),
    .mask_we    (mask_we),
    .mask_wdata (mask_wdata)
  );

  ramp_cmd_t        cmd_arr [NCH];
  logic [LVL_W-1:0] lvl_arr [NCH];
  logic [NCH-1:0]   up_arr;
  logic [NCH-1:0]   dn_arr;

  assign cmd_arr[CH_GAIN] = gain_cmd;
  assign cmd_arr[CH_OUT]  = out_cmd;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ramp
    level_ramp #(.LVL_W(LVL_W), .TICK_W(TICK_W)) u_ramp (
      .clk    (clk),
      .rst_n  (rst_n),
      .period (tick_period),
      .cmd    (cmd_arr[ch]),
      .level  (lvl_arr[ch]),
      .done_up(up_arr[ch]),
      .done_dn(dn_arr[ch])
    );
  end

  logic [NFLAG-1:0] set_vec;
  assign set_vec = {event_i,
                    up_arr[CH_OUT],  dn_arr[CH_OUT],
                    up_arr[CH_GAIN], dn_arr[CH_GAIN]};

  flag_bank u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_vec   (set_vec),
    .clr_vec   (flag_clr),
    .mask_we   (mask_we),
    .mask_wdata(mask_wdata),
    .flag_q    (flag_o),
    .mask_q    (mask_o),
    .irq       (irq_o)
  );

  assign gain_level_o = lvl_arr[CH_GAIN];
  assign out_level_o  = lvl_arr[CH_OUT];

  // R8: a standby write never produces a new gain flag
  assert_standby_no_gain_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    gain_cmd.snap |=> ((flag_o[F_GAIN_UP:F_GAIN_DN] &
                        ~$past(flag_o[F_GAIN_UP:F_GAIN_DN])) == '0));

  // R10: output ramp completes only after a headphone state change started it
  assert_out_idle_no_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_cmd.start && out_cmd.up) |=> (flag_o[F_OUT_DN] == $past(flag_o[F_OUT_DN]) ||
                                       $past(flag_clr[F_OUT_DN])));

endmodule

// File: tb/test_ramp_irq_unit.sv
module test_ramp_irq_unit;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [2:0] event_i = '0;
  logic       irq_o;
  logic [6:0] flag_o, mask_o;
  logic [4:0] gain_level_o, out_level_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ramp_irq_unit i_ramp_irq_unit (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .event_i(event_i), .irq_o(irq_o),
    .flag_o(flag_o), .mask_o(mask_o), .gain_level_o(gain_level_o),
    .out_level_o(out_level_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 8'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse(input logic [2:0] v);
    @(negedge clk);
    event_i = v;
    @(negedge clk);
    event_i = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // Tick period 1 -> one step every 2 cycles, 31 steps per full ramp
  localparam int STEP = 2;
  localparam int FULL = 31 * STEP;

  task automatic t_reset();
    chk("R1 flags", flag_o, 0);
    chk("R1 mask", mask_o, 7'h7F);
    chk("R1 irq", irq_o, 0);
    chk("R1 gain level", gain_level_o, 0);
    chk("R1 out level", out_level_o, 0);
  endtask

  task automatic t_events_mask();
    pulse(3'b010);
    chk("R2 jack -> bit5", flag_o, 7'h20);
    chk("R4 masked irq", irq_o, 0);
    wr(3, 8'h00);
    chk("R4 unmasked irq", irq_o, 1);
    wr(2, 8'h20);
    chk("R3 w1c jack", flag_o, 0);
    chk("R4 irq after clear", irq_o, 0);
    pulse(3'b100);
    chk("R2 screl -> bit6", flag_o, 7'h40);
    pulse(3'b001);
    chk("R2 short -> bit4, sticky", flag_o, 7'h50);
    wr(2, 8'h10);
    chk("R3 partial clear", flag_o, 7'h40);
    wr(2, 8'h7F);
    chk("R3 clear all", flag_o, 0);
    wr(3, 8'h20);
    pulse(3'b010);
    chk("R4 jack masked irq", irq_o, 0);
    pulse(3'b001);
    chk("R4 short unmasked irq", irq_o, 1);
    wr(2, 8'h7F);
    wr(3, 8'h00);
    chk("R4 irq after clear all", irq_o, 0);
  endtask

  task automatic t_set_wins();
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'd2; cfg_wdata = 8'h40; event_i = 3'b100;
    @(negedge clk);
    cfg_we = 1'b0; event_i = '0;
    chk("R5 set beats clear", flag_o, 7'h40);
    wr(2, 8'h7F);
  endtask

  task automatic t_gain_ramps();
    wr(0, 8'h00);
    idle(FULL - 1);
    chk("R6 gain one before end", gain_level_o, 30);
    chk("R6 no flag before end", flag_o, 0);
    idle(1);
    chk("R6 gain at max", gain_level_o, 31);
    chk("R6 gain-up flag", flag_o, 7'h02);
    chk("R4 irq on gain-up", irq_o, 1);
    wr(2, 8'h7F);
    wr(0, 8'h80);
    idle(FULL - 1);
    chk("R6 gain one above zero", gain_level_o, 1);
    idle(1);
    chk("R6 gain at zero", gain_level_o, 0);
    chk("R6 gain-down flag", flag_o, 7'h01);
    wr(2, 8'h7F);
  endtask

  task automatic t_reversal();
    wr(0, 8'h00);
    idle(10 * STEP);
    chk("R9 mid-ramp level", gain_level_o, 10);
    wr(0, 8'h80);
    idle(10 * STEP - 1);
    chk("R9 reversed level", gain_level_o, 1);
    idle(1);
    chk("R9 reversed at zero", gain_level_o, 0);
    chk("R9 only down flag", flag_o, 7'h01);
    wr(2, 8'h7F);
  endtask

  task automatic t_standby();
    wr(0, 8'h10);
    chk("R8 standby snap up", gain_level_o, 31);
    chk("R8 no flag on snap", flag_o, 0);
    idle(FULL);
    chk("R8 level held", gain_level_o, 31);
    chk("R8 still no flag", flag_o, 0);
    wr(0, 8'h90);
    chk("R8 standby snap down", gain_level_o, 0);
    idle(8);
    chk("R8 no flag after mute", flag_o, 0);
  endtask

  task automatic t_output_stage();
    wr(1, 8'h08);
    idle(FULL + 8);
    chk("R10 still off level", out_level_o, 0);
    chk("R10 still off flags", flag_o, 0);
    wr(1, 8'h00);
    idle(FULL - 1);
    chk("R10 out one before end", out_level_o, 30);
    idle(1);
    chk("R10 out at max", out_level_o, 31);
    chk("R10 ramp-up flag", flag_o, 7'h08);
    wr(2, 8'h7F);
    wr(1, 8'h80);
    idle(FULL);
    chk("R10 out at zero", out_level_o, 0);
    chk("R10 ramp-down flag", flag_o, 7'h04);
    wr(2, 8'h7F);
  endtask

  task automatic t_tick();
    wr(4, 3);
    wr(0, 8'h00);
    idle(31 * 4 - 1);
    chk("R7 slow tick one before end", gain_level_o, 30);
    chk("R7 slow tick no flag yet", flag_o, 0);
    idle(1);
    chk("R7 slow tick end", gain_level_o, 31);
    chk("R7 slow tick flag", flag_o, 7'h02);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_events_mask();
    t_set_wins();
    t_gain_ramps();
    t_reversal();
    t_standby();
    t_output_stage();
    t_tick();
    finish_run();
  end

  initial begin
    #(8 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule